// File: doc/BRIEF.md
# Shift-Leak Integrate-and-Fire Neuron

This block models one leaky integrate-and-fire neuron using only fixed-point shifts and additions. A signed membrane-potential register leaks on every enabled timestep by losing a right-shifted copy of itself. The stored weight is then added when the input spike is present. If the result reaches the programmable threshold, the neuron emits an output spike and its potential returns to zero.

An external controller steps the neuron by holding `en` high. It can freeze the neuron completely by dropping `en`, so that a neuron whose outcome is already decided stops toggling. The weight, the decay shift and the threshold sit in three configuration registers. All three load together while a write strobe is high.

Top module: `lif_neuron`

## Requirements
- R1: Synchronous active-high reset clears the potential to 0 and the output spike to 0. It sets the weight to 0, the decay shift to 1 and the threshold to the largest positive value (32767 at 16 bits).
- R2: On an enabled timestep the potential first leaks to v - (v >>> s), where s is the 3-bit decay shift and >>> is an arithmetic shift. A non-negative potential therefore never grows without input.
- R3: After the leak, the signed weight is added when `spike_in` is 1. Nothing is added when `spike_in` is 0.
- R4: The leaked-plus-weight sum saturates at 32767 and at -32768 instead of wrapping.
- R5: When the saturated sum is greater than or equal to the signed threshold, `spike_out` is 1 after that clock edge and the potential is 0 on the same cycle.
- R6: `spike_out` is 0 after any enabled timestep whose sum stays below the threshold, so a single crossing gives a pulse of exactly one step.
- R7: While `en` is 0, the potential and `spike_out` keep their values and no leak is applied.
- R8: The configuration registers load `cfg_weight`, `cfg_shift` and `cfg_thresh` only on an edge where `cfg_we` is 1. A timestep on that same edge still uses the previous values.
- R9: A decay shift of 0 is a full leak: the potential becomes just the weight contribution of that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Timestep enable; low freezes the neuron |
| spike_in | input | 1 | Input spike for this timestep |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_weight | input | 16 | Signed synaptic weight to load |
| cfg_shift | input | 3 | Decay shift amount to load |
| cfg_thresh | input | 16 | Signed firing threshold to load |
| spike_out | output | 1 | Registered output spike |
| potential_out | output | 16 | Registered signed membrane potential |

## Verification
On every cycle the assertions check four behaviours:
- reset clearing,
- the potential being zero whenever a spike is shown,
- the complete freeze while disabled,
- the configuration registers staying unchanged without a write strobe.

They also check that a non-negative potential never rises without input. The exact leak arithmetic needs the bench's scenarios driven against an independent reference model. So do the firing point at equality with the threshold, saturation at both rails, the full leak at shift 0, and the rule that a write uses old values on its own edge.

// File: rtl/lif_pkg.sv
package lif_pkg;
  localparam int DEF_VW = 16;
  localparam int DEF_SW = 3;

  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_HIGH = 2'd1,
    SAT_LOW  = 2'd2
  } sat_kind_e;
endpackage

// File: rtl/lif_cfg_regs.sv
module lif_cfg_regs #(
  parameter int VW = lif_pkg::DEF_VW,
  parameter int SW = lif_pkg::DEF_SW,
  parameter int RST_SHIFT = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic signed [VW-1:0] weight_d,
  input  logic [SW-1:0]        shift_d,
  input  logic signed [VW-1:0] thresh_d,
  output logic signed [VW-1:0] weight_q,
  output logic [SW-1:0]        shift_q,
  output logic signed [VW-1:0] thresh_q
);
  localparam logic signed [VW-1:0] THR_RST = {1'b0, {(VW-1){1'b1}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      weight_q <= '0;
      shift_q  <= SW'(RST_SHIFT);
      thresh_q <= THR_RST;
    end else if (we) begin
      weight_q <= weight_d;
      shift_q  <= shift_d;
      thresh_q <= thresh_d;
    end
  end
endmodule

// File: rtl/lif_leak_integrate.sv
module lif_leak_integrate #(
  parameter int VW = lif_pkg::DEF_VW,
  parameter int SW = lif_pkg::DEF_SW
) (
  input  logic signed [VW-1:0] v_cur,
  input  logic [SW-1:0]        shift,
  input  logic                 spike_in,
  input  logic signed [VW-1:0] weight,
  output logic signed [VW-1:0] v_sum,
  output lif_pkg::sat_kind_e   sat_kind
);
  localparam logic signed [VW-1:0] VMAX = {1'b0, {(VW-1){1'b1}}};
  localparam logic signed [VW-1:0] VMIN = {1'b1, {(VW-1){1'b0}}};

  logic signed [VW-1:0] leaked;
  logic signed [VW:0]   wide;

  always_comb begin
    leaked = v_cur - (v_cur >>> shift);
    wide   = {leaked[VW-1], leaked} +
             (spike_in ? {weight[VW-1], weight} : {(VW+1){1'b0}});
    if (wide[VW] != wide[VW-1]) begin
      sat_kind = wide[VW] ? lif_pkg::SAT_LOW : lif_pkg::SAT_HIGH;
      v_sum    = wide[VW] ? VMIN : VMAX;
    end else begin
      sat_kind = lif_pkg::SAT_NONE;
      v_sum    = wide[VW-1:0];
    end
  end
endmodule

// File: rtl/lif_fire_cmp.sv
module lif_fire_cmp #(
  parameter int VW = lif_pkg::DEF_VW
) (
  input  logic signed [VW-1:0] v_sum,
  input  logic signed [VW-1:0] thresh,
  output logic                 fire,
  output logic signed [VW-1:0] v_next
);
  always_comb begin
    fire   = (v_sum >= thresh);
    v_next = fire ? '0 : v_sum;
  end
endmodule

// File: rtl/lif_neuron.sv
module lif_neuron #(
  parameter int VW = lif_pkg::DEF_VW,
  parameter int SW = lif_pkg::DEF_SW,
  parameter int RST_SHIFT = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 spike_in,
  input  logic                 cfg_we,
  input  logic signed [VW-1:0] cfg_weight,
  input  logic [SW-1:0]        cfg_shift,
  input  logic signed [VW-1:0] cfg_thresh,
  output logic                 spike_out,
  output logic signed [VW-1:0] potential_out
);
  logic signed [VW-1:0] weight_q;
  logic [SW-1:0]        shift_q;
  logic signed [VW-1:0] thresh_q;
  logic signed [VW-1:0] v_q;
  logic signed [VW-1:0] v_sum;
  logic signed [VW-1:0] v_next;
  logic                 fire;
  lif_pkg::sat_kind_e   sat_kind;
  logic                 spk_q;

  lif_cfg_regs #(.VW(VW), .SW(SW), .RST_SHIFT(RST_SHIFT)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we),
    .weight_d(cfg_weight), .shift_d(cfg_shift), .thresh_d(cfg_thresh),
    .weight_q(weight_q), .shift_q(shift_q), .thresh_q(thresh_q)
  );

  lif_leak_integrate #(.VW(VW), .SW(SW)) u_int (
    .v_cur(v_q), .shift(shift_q), .spike_in(spike_in), .weight(weight_q),
    .v_sum(v_sum), .sat_kind(sat_kind)
  );

  lif_fire_cmp #(.VW(VW)) u_cmp (
    .v_sum(v_sum), .thresh(thresh_q), .fire(fire), .v_next(v_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= '0;
      spk_q <= 1'b0;
    end else if (en) begin
      v_q   <= v_next;
      spk_q <= fire;
    end
  end

  assign potential_out = v_q;
  assign spike_out     = spk_q;
endmodule

// File: rtl/lif_neuron_chk.sv
module lif_neuron_chk #(
  parameter int VW = lif_pkg::DEF_VW,
  parameter int SW = lif_pkg::DEF_SW
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 en,
  input logic                 spike_in,
  input logic                 cfg_we,
  input logic                 spike_out,
  input logic signed [VW-1:0] potential_out,
  input logic signed [VW-1:0] weight_q,
  input logic [SW-1:0]        shift_q,
  input logic signed [VW-1:0] thresh_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (potential_out == '0 && !spike_out));

  // R5
  fire_zero_chk: assert property (@(posedge clk) disable iff (rst)
    spike_out |-> potential_out == '0);

  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(potential_out) && $stable(spike_out)));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(weight_q) && $stable(shift_q) && $stable(thresh_q)));

  // R2
  leak_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !spike_in && potential_out >= 0) |=>
      (potential_out >= 0 && potential_out <= $past(potential_out)));
endmodule

bind lif_neuron lif_neuron_chk #(.VW(VW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .spike_in(spike_in), .cfg_we(cfg_we),
  .spike_out(spike_out), .potential_out(potential_out),
  .weight_q(weight_q), .shift_q(shift_q), .thresh_q(thresh_q)
);

// File: tb/lif_neuron_tb.sv
module lif_neuron_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 16;
  localparam int SW = 3;

  typedef struct {
    logic       spk;
    int         pot;
    string      tag;
  } exp_t;

  logic clk = 0, rst = 1, en = 0, spike_in = 0, cfg_we = 0;
  logic signed [VW-1:0] cfg_weight = 0, cfg_thresh = 0;
  logic [SW-1:0] cfg_shift = 0;
  logic spike_out;
  logic signed [VW-1:0] potential_out;

  exp_t q[$];
  int checks = 0, fails = 0;
  int m_v = 0, m_w = 0, m_s = 1, m_t = 32767;
  logic m_spk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lif_neuron u_dut (
    .clk(clk), .rst(rst), .en(en), .spike_in(spike_in), .cfg_we(cfg_we),
    .cfg_weight(cfg_weight), .cfg_shift(cfg_shift), .cfg_thresh(cfg_thresh),
    .spike_out(spike_out), .potential_out(potential_out)
  );

  // monitor: compares results one edge after the driver queued them
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (spike_out !== e.spk || int'(potential_out) != e.pot) begin
        fails++;
        $display("FAIL %s: got spike=%0b pot=%0d, expected spike=%0b pot=%0d",
                 e.tag, spike_out, potential_out, e.spk, e.pot);
      end
    end
  end

  // driver: one clock edge with given inputs; reference model updates the expectation
  task automatic step(input logic e, input logic s, input logic we,
                      input int w, input int sh, input int th, input string tag);
    exp_t x;
    int lk, sum;
    @(negedge clk);
    en = e; spike_in = s; cfg_we = we;
    cfg_weight = VW'(w); cfg_shift = SW'(sh); cfg_thresh = VW'(th);
    if (e) begin
      lk  = m_v - (m_v >>> m_s);
      sum = lk + (s ? m_w : 0);
      if (sum > 32767) sum = 32767;
      if (sum < -32768) sum = -32768;
      if (sum >= m_t) begin m_spk = 1; m_v = 0; end
      else begin m_spk = 0; m_v = sum; end
    end
    if (we) begin m_w = w; m_s = sh; m_t = th; end
    @(posedge clk);
    x.spk = m_spk; x.pot = m_v; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic tick(input logic s, input string tag);
    step(1'b1, s, 1'b0, 16'sd7, 5, -3, tag);  // config bus noise, strobe low
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state: zero potential, no spike
    checks++;
    if (potential_out !== 0 || spike_out !== 0) begin
      fails++;
      $display("FAIL R1: got pot=%0d spike=%0b, expected 0 0", potential_out, spike_out);
    end
    // R1 reset config: weight 0 so spikes add nothing, threshold max so no fire
    tick(1, "R1");
    tick(1, "R1");
    // R8 write with en low: hold state, new config loaded
    step(0, 0, 1, 100, 2, 250, "R8");
    // R3 accumulate, R2 leak with shift 2
    tick(1, "R3");            // 100
    tick(1, "R3");            // 75+100 = 175
    tick(0, "R2");            // 175-43 = 132
    tick(1, "R5");            // 99+100 = 199
    tick(1, "R5");            // 150+100 = 250 >= 250 fire
    tick(0, "R6");            // spike drops, pot 0
    // R7 freeze mid accumulation
    tick(1, "R3");            // 100
    step(0, 1, 0, 0, 0, 0, "R7");
    step(0, 1, 0, 0, 0, 0, "R7");
    tick(0, "R2");            // 75
    // R7 freeze right after a spike: spike held high
    tick(1, "R3");            // 57+100 = 157
    tick(1, "R3");            // 118+100 = 218
    tick(1, "R5");            // 164+100 = 264 fire
    step(0, 0, 0, 0, 0, 0, "R7");
    tick(0, "R6");
    // R8 write on an enabled edge uses old values that step
    tick(1, "R3");            // 100
    step(1, 1, 1, 40, 0, 1000, "R8");   // old: 75+100 = 175
    // R9 shift 0: full leak
    tick(1, "R9");            // 0 + 40 = 40
    tick(0, "R9");            // 0
    tick(1, "R9");            // 40
    // R4 negative saturation
    step(0, 0, 1, -30000, 7, 1000, "R8");
    tick(1, "R4");
    tick(1, "R4");            // saturates to -32768
    tick(1, "R4");
    tick(0, "R2");
    // R4 positive saturation reaching max threshold fires
    step(0, 0, 1, 30000, 7, 32767, "R8");
    step(1, 0, 1, 30000, 7, 32767, "R2");
    repeat (3) tick(1, "R4");
    tick(1, "R5");
    // R5 negative threshold: fires even with no input at zero potential
    step(0, 0, 1, 10, 3, -5, "R8");
    tick(0, "R5");
    tick(0, "R5");
    // R1 reset mid run
    @(negedge clk);
    rst = 1; en = 1;
    @(negedge clk);
    rst = 0; en = 0;
    m_v = 0; m_spk = 0; m_w = 0; m_s = 1; m_t = 32767;
    tick(1, "R1");
    tick(1, "R1");
    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule